// File: doc/BRIEF.md
# Bipolar Return-to-Zero Avionics Word Transmitter

This block sends 32-bit avionics data words on one channel as a three-level return-to-zero signal. Two logic outputs, one for the positive level and one for the negative level, feed an external line driver. When neither output is active, the line sits at the zero level. The block computes the last bit of each word as a parity bit. Each channel chooses odd or even parity on its own.

A host writes the word as two 16-bit halves through a small write port, lower half first. It then issues a start command through a control register. The control register also carries four settings: the parity sense, the bit rate (fast, or eight times slower), the inter-word gap in bit periods, and a repeat flag. In single mode the word goes out once. In repeat mode the same word goes out again after every gap until the host clears the flag. A busy output covers each word and its trailing gap.

Host register map (`hostAddr`):
- 0: lower half of the word.
- 1: upper half of the word.
- 2: control. Bit 0 is start, and it is acted on only in the write cycle. Bit 1 is repeat. Bit 2 selects odd parity when 1 and even parity when 0. Bit 3 selects the slow rate. Bits 15:8 hold the gap in bit periods.
- 3: ignored.

Top module: `a429_tx`

## Requirements
- R1: Bits go out least significant first. Bits 0 to 30 of the transmitted word equal bits 0 to 30 of the loaded word, where the loaded word is {upper half, lower half}.
- R2: Transmitted bit 31 replaces loaded bit 31. It makes the count of ones in the 32 bits odd when control bit 2 was 1 at start, and even when it was 0.
- R3: Each bit period lasts two half periods. A 1 drives `lineHi` and a 0 drives `lineLo`, in the first half only. Both outputs are low in the second half, and they are never high together.
- R4: After bit 31, the block holds both outputs low for G bit periods. G is the control gap field, raised to 4 when the field is below 4.
- R5: A start is accepted only if a lower-half write was followed by an upper-half write since the last accepted start. An upper-half write without a preceding lower-half write does not count. A lower-half write clears any earlier upper-half write.
- R6: `busy` rises in the clock after an accepted start. It stays high through all 32 bits and the gap. It lasts exactly (32+G)·2·H cycles for a single word. A start command issued while busy is ignored, and the halves loaded meanwhile stay ready.
- R7: With repeat set, the same word is sent again right after each gap, with no idle cycle and with `busy` held high. Clearing repeat stops transmission after the current word and its gap.
- R8: The half period H is HALF_FAST clocks at the fast rate. It is HALF_FAST·SLOW_DIV clocks at the slow rate (control bit 3 = 1).
- R9: During and right after reset, `lineHi`, `lineLo` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe, one write per cycle |
| hostAddr | input | 2 | Register select |
| hostWrData | input | 16 | Host write data |
| busy | output | 1 | Word or gap in progress |
| lineHi | output | 1 | Positive-level drive |
| lineLo | output | 1 | Negative-level drive |

## Verification
The assertions assume that the host issues at most one write per cycle, and that no start reaches the block while `rstN` is low. The pulse-width property also assumes that the rate does not change in the middle of a word. The block guarantees this by latching the rate at each word start.

The stimulus applies every host write as a single-cycle strobe, driven on the falling edge. It changes the control register during a word only in two cases: a start that must be ignored, and clearing of the repeat flag. In both cases it keeps the gap and rate fields unchanged.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int GAP_W  = 8;
  localparam int MIN_GAP = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} txState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic takeWord;
    logic reloadFrame;
    logic shiftBit;
    logic drive;
  } txStrobe_t;

  // datapath -> control view of the settings in effect this cycle
  typedef struct packed {
    logic             repeatOn;
    logic             slowOn;
    logic [GAP_W-1:0] gapBits;
  } txCfg_t;
endpackage

// File: rtl/a429_tx_dpath.sv
module a429_tx_dpath
  import a429_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic [15:0] hostWrData,
  input  txStrobe_t   stb,
  output logic        startReq,
  output txCfg_t      cfgNext,
  output logic        lineHi,
  output logic        lineLo
);
  logic [HALF_W-1:0] loHalfQ, hiHalfQ;
  logic              loReadyQ, hiReadyQ;
  logic              cfgRepeatQ, cfgOddQ, cfgSlowQ;
  logic [GAP_W-1:0]  cfgGapQ;
  logic [WORD_W-1:0] wordHoldQ, frameQ;
  logic              oddLatQ;

  logic             ctlWrite, nextOdd, nextRepeat, nextSlow;
  logic [GAP_W-1:0] nextGap;

  function automatic logic [WORD_W-1:0] withParity(input logic [WORD_W-1:0] w,
                                                   input logic odd);
    return {(^w[WORD_W-2:0]) ^ odd, w[WORD_W-2:0]};
  endfunction

  always_comb begin
    ctlWrite   = hostWrEn && (hostAddr == 2'd2);
    nextRepeat = ctlWrite ? hostWrData[1] : cfgRepeatQ;
    nextOdd    = ctlWrite ? hostWrData[2] : cfgOddQ;
    nextSlow   = ctlWrite ? hostWrData[3] : cfgSlowQ;
    nextGap    = ctlWrite ? hostWrData[15:8] : cfgGapQ;
    cfgNext.repeatOn = nextRepeat;
    cfgNext.slowOn   = nextSlow;
    cfgNext.gapBits  = (nextGap < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : nextGap;
    startReq = ctlWrite && hostWrData[0] && loReadyQ && hiReadyQ;
    lineHi   = stb.drive &&  frameQ[0];
    lineLo   = stb.drive && !frameQ[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loHalfQ <= '0; hiHalfQ <= '0;
      loReadyQ <= 1'b0; hiReadyQ <= 1'b0;
      cfgRepeatQ <= 1'b0; cfgOddQ <= 1'b0; cfgSlowQ <= 1'b0; cfgGapQ <= '0;
    end else begin
      if (ctlWrite) begin
        cfgRepeatQ <= nextRepeat;
        cfgOddQ    <= nextOdd;
        cfgSlowQ   <= nextSlow;
        cfgGapQ    <= nextGap;
      end
      if (hostWrEn && hostAddr == 2'd0) begin
        loHalfQ  <= hostWrData;
        loReadyQ <= 1'b1;
        hiReadyQ <= 1'b0;
      end
      if (hostWrEn && hostAddr == 2'd1 && loReadyQ) begin
        hiHalfQ  <= hostWrData;
        hiReadyQ <= 1'b1;
      end
      if (stb.takeWord) begin
        loReadyQ <= 1'b0;
        hiReadyQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordHoldQ <= '0;
      frameQ    <= '0;
      oddLatQ   <= 1'b0;
    end else if (stb.takeWord) begin
      wordHoldQ <= {hiHalfQ, loHalfQ};
      frameQ    <= withParity({hiHalfQ, loHalfQ}, nextOdd);
      oddLatQ   <= nextOdd;
    end else if (stb.reloadFrame) begin
      frameQ <= withParity(wordHoldQ, oddLatQ);
    end else if (stb.shiftBit) begin
      frameQ <= {1'b0, frameQ[WORD_W-1:1]};
    end
  end
endmodule

// File: rtl/a429_tx_ctrl.sv
module a429_tx_ctrl
  import a429_tx_pkg::*;
#(
  parameter int HALF_FAST = 1250,
  parameter int SLOW_DIV  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  txCfg_t    cfgNext,
  output txStrobe_t stb,
  output logic      busy
);
  localparam int HALF_SLOW = HALF_FAST * SLOW_DIV;
  localparam int CNT_W     = $clog2(HALF_SLOW + 1);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int GL_W      = GAP_W + 1;
  localparam logic [CNT_W-1:0] FAST_RL  = CNT_W'(HALF_FAST - 1);
  localparam logic [CNT_W-1:0] SLOW_RL  = CNT_W'(HALF_SLOW - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  txState_e         stateQ;
  logic [CNT_W-1:0] halfCntQ, curRl, newRl;
  logic             firstHalfQ, slowLatQ, halfDone;
  logic [BIT_W-1:0] bitIdxQ;
  logic [GAP_W-1:0] gapLatQ;
  logic [GL_W-1:0]  gapLeftQ;

  always_comb begin
    halfDone = (halfCntQ == '0);
    curRl    = slowLatQ ? SLOW_RL : FAST_RL;
    newRl    = cfgNext.slowOn ? SLOW_RL : FAST_RL;
    stb.takeWord    = (stateQ == ST_IDLE) && startReq;
    stb.reloadFrame = (stateQ == ST_GAP) && halfDone && (gapLeftQ == '0)
                      && cfgNext.repeatOn;
    stb.shiftBit    = (stateQ == ST_SEND) && halfDone && !firstHalfQ
                      && (bitIdxQ != LAST_BIT);
    stb.drive       = (stateQ == ST_SEND) && firstHalfQ;
    busy            = (stateQ != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      halfCntQ   <= '0;
      firstHalfQ <= 1'b0;
      bitIdxQ    <= '0;
      gapLeftQ   <= '0;
      gapLatQ    <= '0;
      slowLatQ   <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (stb.takeWord) begin
          stateQ     <= ST_SEND;
          firstHalfQ <= 1'b1;
          bitIdxQ    <= '0;
          slowLatQ   <= cfgNext.slowOn;
          gapLatQ    <= cfgNext.gapBits;
          halfCntQ   <= newRl;
        end
        ST_SEND: if (halfDone) begin
          halfCntQ <= curRl;
          if (firstHalfQ) begin
            firstHalfQ <= 1'b0;
          end else if (bitIdxQ == LAST_BIT) begin
            stateQ   <= ST_GAP;
            gapLeftQ <= {gapLatQ, 1'b0} - GL_W'(1);
          end else begin
            bitIdxQ    <= bitIdxQ + BIT_W'(1);
            firstHalfQ <= 1'b1;
          end
        end else begin
          halfCntQ <= halfCntQ - CNT_W'(1);
        end
        ST_GAP: if (halfDone) begin
          if (gapLeftQ == '0) begin
            if (cfgNext.repeatOn) begin
              stateQ     <= ST_SEND;
              firstHalfQ <= 1'b1;
              bitIdxQ    <= '0;
              slowLatQ   <= cfgNext.slowOn;
              gapLatQ    <= cfgNext.gapBits;
              halfCntQ   <= newRl;
            end else begin
              stateQ <= ST_IDLE;
            end
          end else begin
            gapLeftQ <= gapLeftQ - GL_W'(1);
            halfCntQ <= curRl;
          end
        end else begin
          halfCntQ <= halfCntQ - CNT_W'(1);
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/a429_tx.sv
module a429_tx
  import a429_tx_pkg::*;
#(
  parameter int HALF_FAST = 1250,
  parameter int SLOW_DIV  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic [15:0] hostWrData,
  output logic        busy,
  output logic        lineHi,
  output logic        lineLo
);
  txStrobe_t stb;
  txCfg_t    cfgNext;
  logic      startReq;

  a429_tx_ctrl #(.HALF_FAST(HALF_FAST), .SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgNext(cfgNext),
    .stb(stb), .busy(busy)
  );

  a429_tx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .stb(stb), .startReq(startReq),
    .cfgNext(cfgNext), .lineHi(lineHi), .lineLo(lineLo)
  );
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk #(
  parameter int HALF_FAST = 1250,
  parameter int SLOW_DIV  = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostWrEn,
  input logic [1:0]  hostAddr,
  input logic [15:0] hostWrData,
  input logic        busy,
  input logic        lineHi,
  input logic        lineLo
);
  int unsigned widthQ;
  always_ff @(posedge clk) begin
    if (!rstN) widthQ <= 0;
    else       widthQ <= (lineHi || lineLo) ? widthQ + 1 : 0;
  end

  // R3
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lineHi && lineLo));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!lineHi && !lineLo));

  // R5
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hostWrEn && hostAddr == 2'd2 && hostWrData[0]));

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineHi || lineLo) |->
      (widthQ == HALF_FAST || widthQ == HALF_FAST * SLOW_DIV));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!busy && !lineHi && !lineLo));
endmodule

bind a429_tx a429_tx_chk #(.HALF_FAST(HALF_FAST), .SLOW_DIV(SLOW_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .hostWrData(hostWrData), .busy(busy), .lineHi(lineHi), .lineLo(lineLo)
);

// File: tb/sim_a429_tx.sv
module sim_a429_tx;
  localparam int H    = 3;
  localparam int SDIV = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [15:0] hostWrData = 16'd0;
  logic        busy, lineHi, lineLo;

  always #2 clk = ~clk;

  a429_tx #(.HALF_FAST(H), .SLOW_DIV(SDIV)) u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .busy(busy), .lineHi(lineHi), .lineLo(lineLo)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  int curHalf = H, expGap = 4, wordsSeen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: decode pulses, rebuild words, compare with the scoreboard
  int cyc = 0, lastRise = -1, bitCnt = 0, pulseLen = 0;
  logic [31:0] shw = '0;
  logic prevHi = 1'b0, prevLo = 1'b0, busyDropped = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (lineHi && lineLo) chk(0, "R3", "both lines high", 1, 0);
      if ((lineHi || lineLo) && !busy) chk(0, "R6", "drive while idle", 1, 0);
      if ((lineHi && !prevHi) || (lineLo && !prevLo)) begin
        if (bitCnt == 0) begin
          if (!busyDropped && lastRise >= 0)
            chk(cyc - lastRise == (1 + expGap) * 2 * curHalf, "R4_R7",
                "word-to-word spacing", cyc - lastRise, (1 + expGap) * 2 * curHalf);
        end else begin
          chk(cyc - lastRise == 2 * curHalf, "R3", "bit spacing",
              cyc - lastRise, 2 * curHalf);
        end
        lastRise = cyc;
        busyDropped = 1'b0;
        shw = {lineHi, shw[31:1]};
        bitCnt++;
        if (bitCnt == 32) begin
          bitCnt = 0;
          wordsSeen++;
          if (expQ.size() == 0) chk(0, "R5_R7", "unexpected word", shw, 0);
          else begin
            logic [31:0] e;
            e = expQ.pop_front();
            // R1 R2: data bits LSB first plus parity bit
            chk(shw == e, "R1_R2", "word", shw, e);
          end
        end
      end
      if (!(lineHi || lineLo) && (prevHi || prevLo))
        chk(pulseLen == curHalf, "R8", "pulse width", pulseLen, curHalf);
      pulseLen = (lineHi || lineLo) ? pulseLen + 1 : 0;
      if (!busy) busyDropped = 1'b1;
    end
    prevHi = lineHi;
    prevLo = lineLo;
  end

  function automatic logic [31:0] frameOf(input logic [31:0] w, input bit odd);
    return {(^w[30:0]) ^ odd, w[30:0]};
  endfunction

  function automatic int effGap(input int g);
    return (g < 4) ? 4 : g;
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  function automatic logic [15:0] ctlWord(input int gap, input bit slow,
                                          input bit odd, input bit rpt, input bit go);
    return {gap[7:0], 4'b0, slow, odd, rpt, go};
  endfunction

  task automatic busyLen(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic idleFor(input int n, input string req);
    int w0;
    bit stayed = 1'b1;
    w0 = wordsSeen;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) stayed = 1'b0;
    end
    chk(stayed && wordsSeen == w0, req, "start ignored, still idle", busy, 0);
  endtask

  task automatic sendSingle(input logic [31:0] w, input bit odd, input bit slow,
                            input int gap, input string req);
    int n, g;
    g = effGap(gap);
    curHalf = slow ? H * SDIV : H;
    expGap = g;
    expQ.push_back(frameOf(w, odd));
    writeReg(2'd0, w[15:0]);
    writeReg(2'd1, w[31:16]);
    writeReg(2'd2, ctlWord(gap, slow, odd, 1'b0, 1'b1));
    busyLen(n);
    chk(n == (32 + g) * 2 * curHalf, req, "busy length", n, (32 + g) * 2 * curHalf);
    chk(expQ.size() == 0, "R1", "word delivered", expQ.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int n, w0;
    repeat (3) @(negedge clk);
    // R9: outputs low while in reset
    chk(!busy && !lineHi && !lineLo, "R9", "reset outputs", {busy, lineHi, lineLo}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !lineHi && !lineLo, "R9", "after reset", {busy, lineHi, lineLo}, 0);

    // R1 R2 R4 R6: even parity, gap field 0 raised to 4
    sendSingle(32'hA5A5_0F0F, 1'b0, 1'b0, 0, "R4_R6");
    // R2: odd parity, bit 31 overwritten, long gap
    sendSingle(32'h8000_0001, 1'b1, 1'b0, 10, "R4");
    // R4: field 2 below minimum -> 4
    sendSingle(32'h7FFF_FFFF, 1'b0, 1'b0, 2, "R4");
    // R8: slow rate
    sendSingle(32'h1234_5678, 1'b1, 1'b1, 4, "R8");

    // R5: start with no halves loaded
    writeReg(2'd2, ctlWord(4, 0, 0, 0, 1));
    idleFor(30, "R5");
    // R5: upper half only
    writeReg(2'd1, 16'hBEEF);
    writeReg(2'd2, ctlWord(4, 0, 0, 0, 1));
    idleFor(30, "R5");
    // R5: upper then lower - lower write cancels upper
    writeReg(2'd1, 16'h1111);
    writeReg(2'd0, 16'h2222);
    writeReg(2'd2, ctlWord(4, 0, 0, 0, 1));
    idleFor(30, "R5");
    // R5: completing with upper makes it valid
    curHalf = H; expGap = 4;
    expQ.push_back(frameOf({16'h3333, 16'h2222}, 1'b0));
    writeReg(2'd1, 16'h3333);
    writeReg(2'd2, ctlWord(4, 0, 0, 0, 1));
    busyLen(n);
    chk(n == 36 * 2 * H, "R5", "accepted after lower then upper", n, 36 * 2 * H);

    // R6: start while busy is ignored, new halves stay ready
    w0 = wordsSeen;
    expQ.push_back(frameOf(32'hC0DE_0001, 1'b0));
    writeReg(2'd0, 16'h0001);
    writeReg(2'd1, 16'hC0DE);
    writeReg(2'd2, ctlWord(4, 0, 0, 0, 1));
    writeReg(2'd0, 16'h5A5A);
    writeReg(2'd1, 16'h0F0F);
    writeReg(2'd2, ctlWord(4, 0, 0, 0, 1));
    busyLen(n);
    chk(n == 36 * 2 * H - 6, "R6", "busy unaffected by second start", n, 36 * 2 * H - 6);
    chk(wordsSeen == w0 + 1, "R6", "one word only", wordsSeen - w0, 1);
    expQ.push_back(frameOf(32'h0F0F_5A5A, 1'b0));
    writeReg(2'd2, ctlWord(4, 0, 0, 0, 1));
    busyLen(n);
    chk(wordsSeen == w0 + 2, "R6", "held halves sent later", wordsSeen - w0, 2);

    // R7: repeat, then clear after three words
    w0 = wordsSeen;
    curHalf = H; expGap = 5;
    for (int i = 0; i < 3; i++) expQ.push_back(frameOf(32'h6E6E_1357, 1'b1));
    writeReg(2'd0, 16'h1357);
    writeReg(2'd1, 16'h6E6E);
    writeReg(2'd2, ctlWord(5, 0, 1, 1, 1));
    n = 0;
    while (wordsSeen < w0 + 3) begin n++; @(negedge clk); end
    writeReg(2'd2, ctlWord(5, 0, 1, 0, 0));
    n += 2;
    begin
      int rest;
      busyLen(rest);
      n += rest;
    end
    chk(n == 3 * 37 * 2 * H, "R7", "continuous busy over three words", n, 3 * 37 * 2 * H);
    idleFor(100, "R7");
    chk(wordsSeen == w0 + 3, "R7", "stopped after clear", wordsSeen - w0, 3);
    chk(expQ.size() == 0, "R7", "all repeats seen", expQ.size(), 0);

    finishRun();
  end
endmodule